// File: doc/BRIEF.md
# Serial Register Port for an Inductive Proximity Sensor

This block is the host-facing register port of an inductive proximity converter. A host master reaches it over a four-wire SPI link: chip-select (active low), serial clock, data in and data out. Every frame starts with one command byte. Its most significant bit picks the direction and its low seven bits pick the register. Data bytes follow. While chip-select stays low, the register address steps by one after each byte, so several neighbouring registers can be read or written in one frame.

The port holds the settings that the converter core and the interrupt logic use: range codes, watchdog code, amplitude/response word, two comparator thresholds, the interrupt pin mode and the conversion-enable bit. It also serves read-only data. When a read frame opens at the proximity address, the live proximity and frequency-count results are captured in the same clock. The frequency bytes that follow in that frame, or in later frames, therefore come from that one conversion. While conversion is enabled, the range, watchdog and amplitude/response settings are frozen.

The serial pins are asynchronous to the system clock `clk`. They pass through a synchronizer and are edge-detected in the `clk` domain. The conversion result inputs are plain levels and are sampled only at the capture moment; they have no handshake.

Top module: `sense_spi_regs`

## Requirements
- R1: The command byte arrives MSB first. Bit 7 set means read and clear means write, and bits 6:0 give the start address. Input bits are taken on serial-clock rising edges.
- R2: A write to the first addressed register commits on the 16th rising serial-clock edge of the frame. If chip-select rises before that edge, no register changes.
- R3: While chip-select stays low after the first data byte, each further group of 8 clocks writes the next address up, for 8×(1+N) clocks in total.
- R4: In a read, the data of the addressed register is shifted out MSB first on falling serial-clock edges, starting at the 8th falling edge. Each further byte comes from the next address up.
- R5: After reset the registers read: 0x00=0x84 (identity), 0x01=0x0E, 0x02=0x14, 0x03=0x45, 0x04=0x1B, 0x07=0xFF, 0x09=0x00, 0x0A=0x00, 0x0B=0x00.
- R6: When a read frame opens at 0x22, the live proximity byte is returned and the 24-bit frequency count is captured. Bits 7:0, 15:8 and 23:16 of the count read at 0x23, 0x24 and 0x25. These bytes keep their value until the next read frame that opens at 0x22.
- R7: While bit 0 of register 0x0B is 1, writes to 0x01 through 0x05 are ignored. Other writable registers still accept writes.
- R8: Writes to read-only addresses (0x00, 0x20, 0x22–0x25) or to unmapped addresses change nothing. Unmapped addresses read 0x00, and 0x20 reads the status input.
- R9: The data-out pin is held low while chip-select is high. Every chip-select fall restarts the bit and byte count, and serial-clock activity with chip-select high has no effect.
- R10: The capture strobe output pulses for exactly one `clk` cycle for each read frame opened at 0x22, and stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_csb | input | 1 | Chip-select, active low |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_sdi | input | 1 | Serial data from the master |
| spi_sdo | output | 1 | Serial data to the master, low when idle |
| prox_in | input | 8 | Live proximity result from the converter |
| freq_in | input | 24 | Live frequency count from the converter |
| status_in | input | 8 | Live status byte, readable at 0x20 |
| rp_max_code | output | 8 | Upper range code (0x01) |
| rp_min_code | output | 8 | Lower range code (0x02) |
| min_freq_code | output | 8 | Oscillator watchdog code (0x03) |
| conv_cfg | output | 8 | Amplitude and response-time word (0x04) |
| thr_high | output | 8 | Comparator upper threshold (0x07) |
| thr_low | output | 8 | Comparator lower threshold (0x09) |
| irq_mode | output | 8 | Interrupt pin mode word (0x0A) |
| conv_enable | output | 1 | Conversion enable, bit 0 of 0x0B |
| snap_strobe | output | 1 | One-cycle pulse when a read at 0x22 opens |

## Verification
A pin change reaches the logic three `clk` cycles later: two synchronizer stages, then the edge-detect register. A committed write shows on the configuration outputs one cycle after that. A data-out bit changes four cycles after its falling serial-clock edge. The bench holds each serial-clock phase for eight `clk` cycles. It samples data-out just before it raises the serial clock, and it reads configuration outputs only after chip-select has risen and a further idle period has passed, so every result has settled before it is sampled. The capture strobe is counted at every `clk` edge over the whole of each frame and compared with the number of reads opened at 0x22.

// File: rtl/sense_spi_pkg.sv
package sense_spi_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  // register addresses (decoded by the host, so fixed)
  localparam logic [ADDR_W-1:0] A_IDENT = 7'h00;
  localparam logic [ADDR_W-1:0] A_RMAX  = 7'h01;
  localparam logic [ADDR_W-1:0] A_RMIN  = 7'h02;
  localparam logic [ADDR_W-1:0] A_WDOG  = 7'h03;
  localparam logic [ADDR_W-1:0] A_CONF  = 7'h04;
  localparam logic [ADDR_W-1:0] A_LOCKL = 7'h01;
  localparam logic [ADDR_W-1:0] A_LOCKH = 7'h05;
  localparam logic [ADDR_W-1:0] A_THI   = 7'h07;
  localparam logic [ADDR_W-1:0] A_TLO   = 7'h09;
  localparam logic [ADDR_W-1:0] A_IMODE = 7'h0A;
  localparam logic [ADDR_W-1:0] A_PWR   = 7'h0B;
  localparam logic [ADDR_W-1:0] A_STAT  = 7'h20;
  localparam logic [ADDR_W-1:0] A_PROX  = 7'h22;
  localparam logic [ADDR_W-1:0] A_FRQ0  = 7'h23;

  // reset values
  localparam logic [BYTE_W-1:0] V_IDENT = 8'h84;
  localparam logic [BYTE_W-1:0] V_RMAX  = 8'h0E;
  localparam logic [BYTE_W-1:0] V_RMIN  = 8'h14;
  localparam logic [BYTE_W-1:0] V_WDOG  = 8'h45;
  localparam logic [BYTE_W-1:0] V_CONF  = 8'h1B;
  localparam logic [BYTE_W-1:0] V_THI   = 8'hFF;
  localparam logic [BYTE_W-1:0] V_TLO   = 8'h00;
  localparam logic [BYTE_W-1:0] V_IMODE = 8'h00;

  typedef struct packed {
    logic [BYTE_W-1:0] rmax;
    logic [BYTE_W-1:0] rmin;
    logic [BYTE_W-1:0] wdog;
    logic [BYTE_W-1:0] conf;
    logic [BYTE_W-1:0] thi;
    logic [BYTE_W-1:0] tlo;
    logic [BYTE_W-1:0] imode;
    logic              pwr;
  } cfg_t;

endpackage

// File: rtl/sense_spi_sync.sv
module sense_spi_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= RST_VAL;
        else if (s == 0) chain_q[s] <= din;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/sense_spi_frame.sv
module sense_spi_frame
  import sense_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csb_lvl,
  input  logic              sclk_lvl,
  input  logic              sdi_lvl,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_load,
  output logic              rd_first,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sdo
);

  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  logic              active_q;
  logic              sclk_prev_q;
  logic [BIT_W-1:0]  bit_q;
  logic              first_q;
  logic              rw_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-2:0] rx_q;
  logic [BYTE_W-1:0] tx_q;
  logic              sdo_q;

  logic              sclk_rise, sclk_fall, byte_done;
  logic [BYTE_W-1:0] rx_nxt;

  assign sclk_rise = active_q & sclk_lvl & ~sclk_prev_q;
  assign sclk_fall = active_q & ~sclk_lvl & sclk_prev_q;
  assign rx_nxt    = {rx_q, sdi_lvl};
  assign byte_done = sclk_rise & (bit_q == LAST_BIT);

  always_comb begin
    rd_addr  = first_q ? rx_nxt[ADDR_W-1:0] : addr_q + ADDR_W'(1);
    rd_load  = byte_done & (first_q ? rx_nxt[BYTE_W-1] : rw_q);
    rd_first = first_q;
    wr_en    = byte_done & ~first_q & ~rw_q;
    wr_addr  = addr_q;
    wr_data  = rx_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      sclk_prev_q <= 1'b0;
      bit_q       <= '0;
      first_q     <= 1'b1;
      rw_q        <= 1'b0;
      addr_q      <= '0;
      rx_q        <= '0;
      tx_q        <= '0;
      sdo_q       <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_lvl;
      if (csb_lvl) begin
        active_q <= 1'b0;
        bit_q    <= '0;
        first_q  <= 1'b1;
        tx_q     <= '0;
        sdo_q    <= 1'b0;
      end else if (!active_q) begin
        // chip-select just fell: fresh frame
        active_q <= 1'b1;
        bit_q    <= '0;
        first_q  <= 1'b1;
        tx_q     <= '0;
        sdo_q    <= 1'b0;
      end else begin
        if (sclk_rise) begin
          rx_q  <= rx_nxt[BYTE_W-2:0];
          bit_q <= bit_q + BIT_W'(1);
          if (byte_done) begin
            first_q <= 1'b0;
            if (first_q) begin
              rw_q   <= rx_nxt[BYTE_W-1];
              addr_q <= rx_nxt[ADDR_W-1:0];
            end else begin
              addr_q <= addr_q + ADDR_W'(1);
            end
            if (rd_load) tx_q <= rd_data;
          end
        end
        if (sclk_fall) begin
          sdo_q <= tx_q[BYTE_W-1];
          tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign sdo = sdo_q;

  // R9: output is quiet the cycle after chip-select is seen high
  p_sdo_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    csb_lvl |=> (sdo == 1'b0));

  // R9: bit and byte count restart after a chip-select fall
  p_count_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!csb_lvl && !active_q) |=> (bit_q == '0 && first_q));

  // R3: each completed data byte moves the address up by one
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !first_q) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));

endmodule

// File: rtl/sense_spi_regfile.sv
module sense_spi_regfile
  import sense_spi_pkg::*;
#(
  parameter int FREQ_BYTES = 3,
  localparam int FREQ_W    = BYTE_W * FREQ_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_load,
  input  logic              rd_first,
  input  logic [BYTE_W-1:0] status_in,
  input  logic [BYTE_W-1:0] prox_in,
  input  logic [FREQ_W-1:0] freq_in,
  output logic [BYTE_W-1:0] rd_data,
  output cfg_t              cfg,
  output logic              snap
);

  cfg_t              cfg_q;
  logic [BYTE_W-1:0] prox_q;
  logic [FREQ_W-1:0] freq_q;
  logic              locked;

  assign snap   = rd_load & rd_first & (rd_addr == A_PROX);
  assign locked = cfg_q.pwr & (wr_addr >= A_LOCKL) & (wr_addr <= A_LOCKH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.rmax  <= V_RMAX;
      cfg_q.rmin  <= V_RMIN;
      cfg_q.wdog  <= V_WDOG;
      cfg_q.conf  <= V_CONF;
      cfg_q.thi   <= V_THI;
      cfg_q.tlo   <= V_TLO;
      cfg_q.imode <= V_IMODE;
      cfg_q.pwr   <= 1'b0;
    end else if (wr_en && !locked) begin
      case (wr_addr)
        A_RMAX:  cfg_q.rmax  <= wr_data;
        A_RMIN:  cfg_q.rmin  <= wr_data;
        A_WDOG:  cfg_q.wdog  <= wr_data;
        A_CONF:  cfg_q.conf  <= wr_data;
        A_THI:   cfg_q.thi   <= wr_data;
        A_TLO:   cfg_q.tlo   <= wr_data;
        A_IMODE: cfg_q.imode <= wr_data;
        A_PWR:   cfg_q.pwr   <= wr_data[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prox_q <= '0;
      freq_q <= '0;
    end else if (snap) begin
      prox_q <= prox_in;
      freq_q <= freq_in;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_IDENT: rd_data = V_IDENT;
      A_RMAX:  rd_data = cfg_q.rmax;
      A_RMIN:  rd_data = cfg_q.rmin;
      A_WDOG:  rd_data = cfg_q.wdog;
      A_CONF:  rd_data = cfg_q.conf;
      A_THI:   rd_data = cfg_q.thi;
      A_TLO:   rd_data = cfg_q.tlo;
      A_IMODE: rd_data = cfg_q.imode;
      A_PWR:   rd_data = {{(BYTE_W-1){1'b0}}, cfg_q.pwr};
      A_STAT:  rd_data = status_in;
      A_PROX:  rd_data = snap ? prox_in : prox_q;
      default: begin
        for (int k = 0; k < FREQ_BYTES; k++) begin
          if (rd_addr == A_FRQ0 + ADDR_W'(k)) rd_data = freq_q[BYTE_W*k +: BYTE_W];
        end
      end
    endcase
  end

  assign cfg = cfg_q;

  // R7: with conversion on, the frozen range register does not move
  p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.pwr |=> $stable(cfg_q.rmax));

  // R6: captured count only changes at a capture
  p_freq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(freq_q));

  // R10: capture strobe is a single-cycle pulse
  p_snap_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> !snap);

endmodule

// File: rtl/sense_spi_regs.sv
module sense_spi_regs
  import sense_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FREQ_BYTES  = 3,
  localparam int FREQ_W     = BYTE_W * FREQ_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_csb,
  input  logic              spi_sclk,
  input  logic              spi_sdi,
  output logic              spi_sdo,
  input  logic [BYTE_W-1:0] prox_in,
  input  logic [FREQ_W-1:0] freq_in,
  input  logic [BYTE_W-1:0] status_in,
  output logic [BYTE_W-1:0] rp_max_code,
  output logic [BYTE_W-1:0] rp_min_code,
  output logic [BYTE_W-1:0] min_freq_code,
  output logic [BYTE_W-1:0] conv_cfg,
  output logic [BYTE_W-1:0] thr_high,
  output logic [BYTE_W-1:0] thr_low,
  output logic [BYTE_W-1:0] irq_mode,
  output logic              conv_enable,
  output logic              snap_strobe
);

  logic [2:0]        pins_s;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [BYTE_W-1:0] rd_data, wr_data;
  logic              rd_load, rd_first, wr_en;
  cfg_t              cfg;

  // bit order {sdi, sclk, csb}; chip-select idles high
  sense_spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({spi_sdi, spi_sclk, spi_csb}),
    .dout (pins_s)
  );

  sense_spi_frame u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .csb_lvl (pins_s[0]),
    .sclk_lvl(pins_s[1]),
    .sdi_lvl (pins_s[2]),
    .rd_data (rd_data),
    .rd_addr (rd_addr),
    .rd_load (rd_load),
    .rd_first(rd_first),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .sdo     (spi_sdo)
  );

  sense_spi_regfile #(.FREQ_BYTES(FREQ_BYTES)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_load  (rd_load),
    .rd_first (rd_first),
    .status_in(status_in),
    .prox_in  (prox_in),
    .freq_in  (freq_in),
    .rd_data  (rd_data),
    .cfg      (cfg),
    .snap     (snap_strobe)
  );

  assign rp_max_code   = cfg.rmax;
  assign rp_min_code   = cfg.rmin;
  assign min_freq_code = cfg.wdog;
  assign conv_cfg      = cfg.conf;
  assign thr_high      = cfg.thi;
  assign thr_low       = cfg.tlo;
  assign irq_mode      = cfg.imode;
  assign conv_enable   = cfg.pwr;

endmodule

// File: tb/sim_sense_spi_regs.sv
module sim_sense_spi_regs;

  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csb = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic        sdo;
  logic [7:0]  prox = 8'h00;
  logic [23:0] freq = 24'h0;
  logic [7:0]  stat = 8'h00;
  logic [7:0]  rmax, rmin, wdog, ccfg, thi, tlo, imode;
  logic        cen, snap;

  int checks = 0, errors = 0, snap_cnt = 0, cyc = 0;

  always #4 clk = ~clk;

  sense_spi_regs u0 (
    .clk(clk), .rst_n(rst_n), .spi_csb(csb), .spi_sclk(sclk), .spi_sdi(sdi),
    .spi_sdo(sdo), .prox_in(prox), .freq_in(freq), .status_in(stat),
    .rp_max_code(rmax), .rp_min_code(rmin), .min_freq_code(wdog),
    .conv_cfg(ccfg), .thr_high(thi), .thr_low(tlo), .irq_mode(imode),
    .conv_enable(cen), .snap_strobe(snap)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (snap) snap_cnt <= snap_cnt + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      sdi = tx[i];
      wait_clk(HALF);
      rx[i] = sdo;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_open();
    csb = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_close();
    wait_clk(HALF);
    csb = 1'b1;
    wait_clk(3 * HALF);
  endtask

  task automatic wr_burst(input logic [6:0] a, input int n, input logic [31:0] d);
    logic [7:0] rx;
    cs_open();
    spi_bits({1'b0, a}, 8, rx);
    for (int k = 0; k < n; k++) spi_bits(d[31 - 8*k -: 8], 8, rx);
    cs_close();
  endtask

  task automatic rd_burst(input logic [6:0] a, input int n, output logic [31:0] v);
    logic [7:0] rx;
    v = '0;
    cs_open();
    spi_bits({1'b1, a}, 8, rx);
    for (int k = 0; k < n; k++) begin
      spi_bits(8'h00, 8, rx);
      v = (v << 8) | 32'(rx);
    end
    cs_close();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R5 rp_max", rmax, 8'h0E);
    check("R5 rp_min", rmin, 8'h14);
    check("R5 wdog", wdog, 8'h45);
    check("R5 conv_cfg", ccfg, 8'h1B);
    check("R5 thr_high", thi, 8'hFF);
    check("R5 thr_low", tlo, 8'h00);
    check("R5 irq_mode", imode, 8'h00);
    check("R5 conv_enable", cen, 1'b0);
    check("R9 sdo idle", sdo, 1'b0);
    check("R10 strobe idle", snap, 1'b0);
    rd_burst(7'h00, 1, v);
    check("R1 R5 identity read", v, 32'h84);
  endtask

  task automatic t_single_write();
    logic [31:0] v;
    wr_burst(7'h07, 1, 32'h5A000000);
    check("R2 thr_high after write", thi, 8'h5A);
    rd_burst(7'h07, 1, v);
    check("R1 readback 0x07", v, 32'h5A);
  endtask

  task automatic t_early_abort();
    logic [7:0] rx;
    cs_open();
    spi_bits(8'h09, 8, rx);
    spi_bits(8'hC3, 7, rx);
    cs_close();
    check("R2 early rise leaves thr_low", tlo, 8'h00);
    wr_burst(7'h09, 1, 32'h33000000);
    check("R9 next frame after abort", tlo, 8'h33);
  endtask

  task automatic t_burst();
    logic [31:0] v;
    wr_burst(7'h01, 4, 32'h11223344);
    check("R3 burst byte0", rmax, 8'h11);
    check("R3 burst byte1", rmin, 8'h22);
    check("R3 burst byte2", wdog, 8'h33);
    check("R3 burst byte3", ccfg, 8'h44);
    rd_burst(7'h01, 4, v);
    check("R4 burst read", v, 32'h11223344);
  endtask

  task automatic t_readonly();
    logic [31:0] v;
    wr_burst(7'h00, 1, 32'h55000000);
    rd_burst(7'h00, 1, v);
    check("R8 identity not writable", v, 32'h84);
    wr_burst(7'h30, 1, 32'h77000000);
    rd_burst(7'h30, 1, v);
    check("R8 unmapped reads zero", v, 32'h0);
    rd_burst(7'h21, 1, v);
    check("R8 0x21 reads zero", v, 32'h0);
    stat = 8'hA5;
    rd_burst(7'h20, 1, v);
    check("R8 status read", v, 32'hA5);
  endtask

  task automatic t_snapshot();
    logic [31:0] v;
    int base;
    prox = 8'h3C; freq = 24'h123456;
    base = snap_cnt;
    rd_burst(7'h22, 4, v);
    check("R6 capture burst", v, 32'h3C563412);
    check("R10 one strobe", snap_cnt - base, 1);
    prox = 8'h99; freq = 24'hABCDEF;
    rd_burst(7'h23, 3, v);
    check("R6 bytes held", v, 32'h563412);
    check("R10 no strobe off 0x22", snap_cnt - base, 1);
    wr_burst(7'h22, 1, 32'h00000000);
    rd_burst(7'h22, 1, v);
    check("R6 new proximity", v, 32'h99);
    rd_burst(7'h23, 3, v);
    check("R6 new count", v, 32'hEFCDAB);
  endtask

  task automatic t_lock();
    wr_burst(7'h0B, 1, 32'h01000000);
    check("R7 conv_enable on", cen, 1'b1);
    wr_burst(7'h01, 1, 32'h66000000);
    check("R7 locked rp_max", rmax, 8'h11);
    wr_burst(7'h04, 1, 32'h07000000);
    check("R7 locked conv_cfg", ccfg, 8'h44);
    wr_burst(7'h07, 1, 32'h77000000);
    check("R7 thr_high still writable", thi, 8'h77);
    wr_burst(7'h0B, 1, 32'h00000000);
    wr_burst(7'h01, 1, 32'h66000000);
    check("R7 unlocked rp_max", rmax, 8'h66);
  endtask

  task automatic t_idle_clock();
    logic sdo_hi;
    sdo_hi = 1'b0;
    sdi = 1'b1;
    for (int i = 0; i < 20; i++) begin
      sclk = ~sclk;
      wait_clk(HALF);
      sdo_hi = sdo_hi | sdo;
    end
    sclk = 1'b0;
    wait_clk(HALF);
    check("R9 sdo low while deselected", sdo_hi, 1'b0);
    wr_burst(7'h0A, 1, 32'h04000000);
    check("R9 clean frame after idle clocks", imode, 8'h04);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_single_write();
    t_early_abort();
    t_burst();
    t_readonly();
    t_snapshot();
    t_lock();
    t_idle_clock();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule